// File: doc/BRIEF.md
# Dual Converter Common Register File

This block is the small shared register set that sits beside a pair of data converters, one acting as master and one as slave. It stores one common control word that both converters read (dual operating mode, interleave delay, DMA configuration and packing mode, clock mode, prescaler and three sensor enable bits). It also offers a read-only status word that mirrors both converters' event flags, a combined data word carrying the latest regular results of the two converters, and two constant identification words.

Software reaches the block over a simple synchronous register bus. A read request is answered with registered data and a one-cycle valid strobe in the following cycle; writes take effect at the clock edge that samples them and return nothing. Each converter reports an activity vector. That vector decides, write by write, which control fields may change. The timing fields stay frozen while either converter is doing anything at all. The DMA fields stay frozen only while a regular conversion is running.

The bus access unit is a two-state machine. `ACC_IDLE` is the quiet state with the read data at zero. `ACC_RDATA` presents read data with the valid strobe. A read request in either state moves it to `ACC_RDATA` (transition *read-accept*). Any cycle without a read request returns it to `ACC_IDLE` (transition *response-done*).

Top module: `dcr_common_regs`

## Requirements
- R1: After reset the control word is all zero, the read valid strobe is low and the read data is zero.
- R2: A read request (select high, write low) is answered in the next cycle with the valid strobe high for exactly that cycle. Cycles that follow a write or an idle cycle have the strobe low.
- R3: The status word at offset 0x00 returns the master flag vector in bits 10:0 and the slave flag vector in bits 26:16. Flag order is ready, end of sampling, end of conversion, end of sequence, overrun, injected end of conversion, injected end of sequence, watchdog 1..3, queue overflow. All other bits are zero.
- R4: The control word at offset 0x08 has dual mode in 4:0, delay in 11:8, DMA config in 13, DMA mode in 15:14, clock mode in 17:16, prescaler in 21:18 and sensor enables in 22, 23 and 24. All other bits read zero. The sensor enables are writable at all times.
- R5: Dual mode, delay, clock mode and prescaler update only when every activity bit of both converters is zero. Activity bits are: bit0 enabled, bit1 calibrating, bit2 regular start, bit3 injected start, bit4 stop request, bit5 disable request.
- R6: DMA config and DMA mode update only when neither converter has its regular start bit (bit2) set. Other activity bits do not block them.
- R7: In a write that hits a locked field, that field keeps its value while the unlocked fields of the same write still update.
- R8: A write whose dual mode value is not one of 0, 1, 2, 3, 5, 6, 7, 9 leaves the dual mode field unchanged.
- R9: With DMA mode other than 3, the combined data word at offset 0x0C returns the master result in bits 15:0 and the slave result in bits 31:16.
- R10: With DMA mode equal to 3, the combined data word returns the master result's low byte in bits 7:0, the slave result's low byte in bits 15:8 and zero above.
- R11: Any offset other than 0x00, 0x08, 0x0C, 0xF0 and 0xF4 reads zero, including unaligned ones. Writes to any offset other than 0x08 leave the control word unchanged.
- R12: Offsets 0xF0 and 0xF4 return the hardware-configuration and version constants set by parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| mst_flags | input | 11 | Master event flags |
| slv_flags | input | 11 | Slave event flags |
| mst_result | input | 16 | Latest master regular result |
| slv_result | input | 16 | Latest slave regular result |
| mst_act | input | 6 | Master activity bits |
| slv_act | input | 6 | Slave activity bits |
| ctrl_word | output | 32 | Current control word for the converters |

## Verification
The write-lock logic is driven with each of the six activity bits raised alone, on the master side and on the slave side. Writes that set fields in both lock groups together then show that each bit locks the timing group and that only the regular start bit locks the DMA group. Writes with all lock inputs idle give a clean baseline. Reserved dual-mode values go into the same writes as changes to other fields, which separates rejection of the one field from rejection of the whole write. The combined data word is read with DMA mode 0, 2 and 3 and with distinct master and slave high bytes, so a packing swap or a wrong mode decode shows up. Status reads use alternating and one-sided flag patterns to expose bit misplacement.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int DCR_AW   = 8;
    localparam int DCR_DW   = 32;
    localparam int FLAG_W   = 11;
    localparam int RES_W    = 16;
    localparam int ACT_W    = 6;
    localparam int NUM_CONV = 2;
    localparam int BYTE_W   = 8;

    localparam logic [DCR_AW-1:0] OFS_STATUS  = 8'h00;
    localparam logic [DCR_AW-1:0] OFS_CTRL    = 8'h08;
    localparam logic [DCR_AW-1:0] OFS_DATA    = 8'h0C;
    localparam logic [DCR_AW-1:0] OFS_HWCFG   = 8'hF0;
    localparam logic [DCR_AW-1:0] OFS_VERSION = 8'hF4;

    // Activity bit positions within each converter's activity vector
    localparam int ACT_EN     = 0;
    localparam int ACT_CAL    = 1;
    localparam int ACT_RSTART = 2;
    localparam int ACT_JSTART = 3;
    localparam int ACT_STOP   = 4;
    localparam int ACT_DIS    = 5;

    localparam logic [1:0] DMA_MODE_BYTE = 2'd3;

    // Slave flags start at this bit of the status word
    localparam int STAT_SLV_LSB = 16;

    typedef struct packed {
        logic       vbat_en;
        logic       tsen;
        logic       vref_en;
        logic [3:0] presc;
        logic [1:0] clk_mode;
        logic [1:0] dma_mode;
        logic       dma_cfg;
        logic [3:0] delay;
        logic [4:0] dual;
    } ctrl_t;

    typedef enum logic [0:0] {
        ACC_IDLE  = 1'b0,
        ACC_RDATA = 1'b1
    } acc_state_t;

    function automatic logic is_legal_dual(input logic [4:0] v);
        logic ok;
        unique case (v)
            5'd0, 5'd1, 5'd2, 5'd3, 5'd5, 5'd6, 5'd7, 5'd9: ok = 1'b1;
            default:                                        ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Place control fields at their bus bit positions
    function automatic logic [DCR_DW-1:0] ctrl_to_word(input ctrl_t c);
        logic [DCR_DW-1:0] w;
        w        = '0;
        w[4:0]   = c.dual;
        w[11:8]  = c.delay;
        w[13]    = c.dma_cfg;
        w[15:14] = c.dma_mode;
        w[17:16] = c.clk_mode;
        w[21:18] = c.presc;
        w[22]    = c.vref_en;
        w[23]    = c.tsen;
        w[24]    = c.vbat_en;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [DCR_DW-1:0] w);
        ctrl_t c;
        c.dual     = w[4:0];
        c.delay    = w[11:8];
        c.dma_cfg  = w[13];
        c.dma_mode = w[15:14];
        c.clk_mode = w[17:16];
        c.presc    = w[21:18];
        c.vref_en  = w[22];
        c.tsen     = w[23];
        c.vbat_en  = w[24];
        return c;
    endfunction

endpackage

// File: rtl/dcr_lock_gen.sv
module dcr_lock_gen
    import dcr_pkg::*;
#(
    parameter int N_CONV = NUM_CONV,
    parameter int A_W    = ACT_W
) (
    input  logic [N_CONV-1:0][A_W-1:0] act,
    output logic                       cfg_lock,
    output logic                       dma_lock
);

    logic [N_CONV-1:0] conv_busy;
    logic [N_CONV-1:0] conv_running;

    // Per-converter reduction of its activity bits
    for (genvar gi = 0; gi < N_CONV; gi++) begin : g_conv
        assign conv_busy[gi]    = |act[gi];
        assign conv_running[gi] = act[gi][ACT_RSTART];
    end

    assign cfg_lock = |conv_busy;
    assign dma_lock = |conv_running;

endmodule

// File: rtl/dcr_ctrl_reg.sv
module dcr_ctrl_reg
    import dcr_pkg::*;
#(
    parameter int DW = DCR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          cfg_lock,
    input  logic          dma_lock,
    output ctrl_t         ctrl_q
);

    ctrl_t wr_fields;
    ctrl_t ctrl_d;
    logic  wr_unused_bits;

    assign wr_fields      = word_to_ctrl(wdata);
    assign wr_unused_bits = ^{wdata[DW-1:25], wdata[12], wdata[7:5]};

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            // sensor enables carry no lock
            ctrl_d.vref_en = wr_fields.vref_en;
            ctrl_d.tsen    = wr_fields.tsen;
            ctrl_d.vbat_en = wr_fields.vbat_en;
            if (!dma_lock) begin
                ctrl_d.dma_cfg  = wr_fields.dma_cfg;
                ctrl_d.dma_mode = wr_fields.dma_mode;
            end
            if (!cfg_lock) begin
                ctrl_d.delay    = wr_fields.delay;
                ctrl_d.clk_mode = wr_fields.clk_mode;
                ctrl_d.presc    = wr_fields.presc;
                if (is_legal_dual(wr_fields.dual)) begin
                    ctrl_d.dual = wr_fields.dual;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/dcr_data_pack.sv
module dcr_data_pack
    import dcr_pkg::*;
#(
    parameter int RW = RES_W,
    parameter int DW = DCR_DW
) (
    input  logic [RW-1:0] mst_res,
    input  logic [RW-1:0] slv_res,
    input  logic [1:0]    dma_mode,
    output logic [DW-1:0] packed_word
);

    localparam int PAD_W = DW - 2 * BYTE_W;

    always_comb begin
        if (dma_mode == DMA_MODE_BYTE) begin
            packed_word = {{PAD_W{1'b0}}, slv_res[BYTE_W-1:0], mst_res[BYTE_W-1:0]};
        end else begin
            packed_word = {slv_res, mst_res};
        end
    end

endmodule

// File: rtl/dcr_bus_fsm.sv
module dcr_bus_fsm
    import dcr_pkg::*;
#(
    parameter int AW = DCR_AW,
    parameter int DW = DCR_DW,
    parameter logic [DW-1:0] HWCFG_WORD = '0,
    parameter logic [DW-1:0] VER_WORD   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] status_word,
    input  logic [DW-1:0] ctrl_word,
    input  logic [DW-1:0] data_word,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          ctrl_wr_en
);

    acc_state_t    state_q;
    acc_state_t    state_d;
    logic          rd_req;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;

    assign rd_req     = sel && !wr;
    assign ctrl_wr_en = sel && wr && (addr == OFS_CTRL);

    // next state: read-accept / response-done
    always_comb begin
        unique case (state_q)
            ACC_IDLE:  state_d = rd_req ? ACC_RDATA : ACC_IDLE;
            ACC_RDATA: state_d = rd_req ? ACC_RDATA : ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    always_comb begin
        unique case (addr)
            OFS_STATUS:  rd_mux = status_word;
            OFS_CTRL:    rd_mux = ctrl_word;
            OFS_DATA:    rd_mux = data_word;
            OFS_HWCFG:   rd_mux = HWCFG_WORD;
            OFS_VERSION: rd_mux = VER_WORD;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rd_req ? rd_mux : '0;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ACC_RDATA: begin
                rvalid = 1'b1;
                rdata  = rdata_q;
            end
            default: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
        endcase
    end

endmodule

// File: rtl/dcr_common_regs.sv
module dcr_common_regs
    import dcr_pkg::*;
#(
    parameter logic [31:0] HWCFG_VALUE   = 32'h0000_1122,
    parameter logic [31:0] VERSION_VALUE = 32'h0000_0053
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    input  logic [10:0] mst_flags,
    input  logic [10:0] slv_flags,
    input  logic [15:0] mst_result,
    input  logic [15:0] slv_result,
    input  logic [5:0]  mst_act,
    input  logic [5:0]  slv_act,
    output logic [31:0] ctrl_word
);

    localparam int STAT_GAP_W = STAT_SLV_LSB - FLAG_W;
    localparam int STAT_TOP_W = DCR_DW - STAT_SLV_LSB - FLAG_W;

    logic [NUM_CONV-1:0][ACT_W-1:0] act_all;
    logic                           cfg_lock;
    logic                           dma_lock;
    logic                           ctrl_wr_en;
    ctrl_t                          ctrl_q;
    logic [DCR_DW-1:0]              status_word;
    logic [DCR_DW-1:0]              data_word;

    assign act_all[0] = mst_act;
    assign act_all[1] = slv_act;

    assign status_word = {{STAT_TOP_W{1'b0}}, slv_flags, {STAT_GAP_W{1'b0}}, mst_flags};
    assign ctrl_word   = ctrl_to_word(ctrl_q);

    dcr_lock_gen #(
        .N_CONV (NUM_CONV),
        .A_W    (ACT_W)
    ) lock_i (
        .act      (act_all),
        .cfg_lock (cfg_lock),
        .dma_lock (dma_lock)
    );

    dcr_ctrl_reg #(
        .DW (DCR_DW)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr_en),
        .wdata    (bus_wdata),
        .cfg_lock (cfg_lock),
        .dma_lock (dma_lock),
        .ctrl_q   (ctrl_q)
    );

    dcr_data_pack #(
        .RW (RES_W),
        .DW (DCR_DW)
    ) pack_i (
        .mst_res     (mst_result),
        .slv_res     (slv_result),
        .dma_mode    (ctrl_q.dma_mode),
        .packed_word (data_word)
    );

    dcr_bus_fsm #(
        .AW         (DCR_AW),
        .DW         (DCR_DW),
        .HWCFG_WORD (HWCFG_VALUE),
        .VER_WORD   (VERSION_VALUE)
    ) bus_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (bus_sel),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .status_word (status_word),
        .ctrl_word   (ctrl_word),
        .data_word   (data_word),
        .rdata       (bus_rdata),
        .rvalid      (bus_rvalid),
        .ctrl_wr_en  (ctrl_wr_en)
    );

endmodule

// File: rtl/dcr_common_regs_chk.sv
module dcr_common_regs_chk
    import dcr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        bus_rvalid,
    input logic [10:0] mst_flags,
    input logic [10:0] slv_flags,
    input logic [5:0]  mst_act,
    input logic [5:0]  slv_act,
    input logic [31:0] ctrl_word
);

    logic any_act;
    logic any_run;
    logic ctrl_wr;

    assign any_act = (|mst_act) || (|slv_act);
    assign any_run = mst_act[ACT_RSTART] || slv_act[ACT_RSTART];
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == OFS_CTRL);

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid); // R2

    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid); // R2

    AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_STATUS) |=>
        (bus_rdata == {5'b0, $past(slv_flags), 5'b0, $past(mst_flags)})); // R3

    AST_CFG_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && any_act) |=>
        ($stable(ctrl_word[4:0]) && $stable(ctrl_word[11:8]) && $stable(ctrl_word[21:16]))); // R5

    AST_DMA_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && any_run) |=> $stable(ctrl_word[15:13])); // R6

    AST_DUAL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        is_legal_dual(ctrl_word[4:0])); // R8

    AST_CTRL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_word)); // R11

endmodule

bind dcr_common_regs dcr_common_regs_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .mst_flags  (mst_flags),
    .slv_flags  (slv_flags),
    .mst_act    (mst_act),
    .slv_act    (slv_act),
    .ctrl_word  (ctrl_word)
);

// File: tb/dcr_common_regs_tb_top.sv
`timescale 1ns/1ps
module dcr_common_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [10:0] mst_flags = '0;
    logic [10:0] slv_flags = '0;
    logic [15:0] mst_result = '0;
    logic [15:0] slv_result = '0;
    logic [5:0]  mst_act = '0;
    logic [5:0]  slv_act = '0;
    logic [31:0] ctrl_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dcr_common_regs dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .mst_flags  (mst_flags),
        .slv_flags  (slv_flags),
        .mst_result (mst_result),
        .slv_result (slv_result),
        .mst_act    (mst_act),
        .slv_act    (slv_act),
        .ctrl_word  (ctrl_word)
    );

    // Write-lock table: write to addr with activity, then expect control word
    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [5:0]  mact;
        logic [5:0]  sact;
        logic [31:0] exp_ctrl;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{4'd4,  8'h08, 32'h0155_A503, 6'h00, 6'h00, 32'h0155_A503}, // R4 all fields
        '{4'd8,  8'h08, 32'hFFFF_FFFF, 6'h00, 6'h00, 32'h01FF_EF03}, // R8 dual 31 rejected
        '{4'd8,  8'h08, 32'h0000_0004, 6'h00, 6'h00, 32'h0000_0003}, // R8 dual 4 rejected
        '{4'd7,  8'h08, 32'h01FF_EF06, 6'h01, 6'h00, 32'h01C0_E003}, // R7 enabled locks timing only
        '{4'd5,  8'h08, 32'h0000_0000, 6'h00, 6'h02, 32'h0000_0003}, // R5 calibration
        '{4'd6,  8'h08, 32'h003F_EF09, 6'h04, 6'h00, 32'h0000_0003}, // R6 master regular start
        '{4'd6,  8'h08, 32'h0000_E000, 6'h00, 6'h04, 32'h0000_0003}, // R6 slave regular start
        '{4'd6,  8'h08, 32'h0000_6000, 6'h00, 6'h08, 32'h0000_6003}, // R6 injected start leaves DMA free
        '{4'd5,  8'h08, 32'h0000_0A09, 6'h10, 6'h00, 32'h0000_0003}, // R5 stop request
        '{4'd5,  8'h08, 32'h0000_0105, 6'h00, 6'h20, 32'h0000_0003}, // R5 disable request
        '{4'd5,  8'h08, 32'h0000_0F09, 6'h00, 6'h00, 32'h0000_0F09}, // R5 idle accepts
        '{4'd11, 8'h00, 32'hFFFF_FFFF, 6'h00, 6'h00, 32'h0000_0F09}, // R11 status read-only
        '{4'd11, 8'h0C, 32'h0000_0000, 6'h00, 6'h00, 32'h0000_0F09}, // R11 data read-only
        '{4'd11, 8'hF0, 32'h0000_0000, 6'h00, 6'h00, 32'h0000_0F09}, // R11 config read-only
        '{4'd11, 8'h09, 32'h0000_0000, 6'h00, 6'h00, 32'h0000_0F09}  // R11 unaligned
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                            input logic [5:0] ma, input logic [5:0] sa);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        mst_act = ma; slv_act = sa;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        mst_act = '0; slv_act = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    initial begin
        logic [31:0] rd;
        logic        rv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl_word", ctrl_word, 32'h0);
        check("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;

        // R2 response strobe
        do_read(8'h08, rd, rv);
        check("R2 rvalid after read", {31'b0, rv}, 32'h1);
        check("R4 ctrl readback after reset", rd, 32'h0);
        @(negedge clk);
        check("R2 rvalid drops", {31'b0, bus_rvalid}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i].addr, VECS[i].wdata, VECS[i].mact, VECS[i].sact);
            check($sformatf("R2 no rvalid after write vec %0d", i), {31'b0, bus_rvalid}, 32'h0);
            check($sformatf("R%0d ctrl port vec %0d", VECS[i].req, i), ctrl_word, VECS[i].exp_ctrl);
            do_read(8'h08, rd, rv);
            check($sformatf("R%0d ctrl read vec %0d", VECS[i].req, i), rd, VECS[i].exp_ctrl);
        end

        // R3 status mirror
        mst_flags = 11'h7FF; slv_flags = 11'h000;
        do_read(8'h00, rd, rv);
        check("R3 master only", rd, 32'h0000_07FF);
        mst_flags = 11'h555; slv_flags = 11'h2AA;
        do_read(8'h00, rd, rv);
        check("R3 alternating", rd, 32'h02AA_0555);

        // R9 normal packing (DMA mode currently 0)
        mst_result = 16'h1234; slv_result = 16'hABCD;
        do_read(8'h0C, rd, rv);
        check("R9 mode0 packing", rd, 32'hABCD_1234);
        do_write(8'h08, 32'h0000_8000, 6'h00, 6'h00);
        do_read(8'h0C, rd, rv);
        check("R9 mode2 packing", rd, 32'hABCD_1234);
        // R10 byte packing
        do_write(8'h08, 32'h0000_C000, 6'h00, 6'h00);
        do_read(8'h0C, rd, rv);
        check("R10 byte packing", rd, 32'h0000_CD34);
        mst_result = 16'hFF5A; slv_result = 16'h00C3;
        do_read(8'h0C, rd, rv);
        check("R10 byte packing 2", rd, 32'h0000_C35A);

        // R12 constants
        do_read(8'hF0, rd, rv);
        check("R12 hwcfg", rd, 32'h0000_1122);
        do_read(8'hF4, rd, rv);
        check("R12 version", rd, 32'h0000_0053);

        // R11 unmapped reads
        do_read(8'h04, rd, rv);
        check("R11 offset 04", rd, 32'h0);
        do_read(8'hFC, rd, rv);
        check("R11 offset FC", rd, 32'h0);
        do_read(8'h0A, rd, rv);
        check("R11 offset 0A", rd, 32'h0);
        check("R2 rvalid on unmapped", {31'b0, rv}, 32'h1);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule